// File: doc/BRIEF.md
# Multicycle Five-Instruction Datapath

This block is the data side of a small 32-bit processor that spends several clocks on each instruction. It holds the program counter and a 32-entry register file. Five staging registers carry values from one step to the next: an instruction register, two operand registers A and B, a result register S and a memory-data register M. Between them sit an ALU, immediate extension and next-PC logic. The block supports register-register add and subtract, OR with an immediate, load word, store word and branch-if-equal. It makes no decisions of its own. Every load enable, operand select and write strobe comes in as a control input from an external sequencer, and the block hands the sequencer the opcode and an equality flag.

The instruction memory port presents the PC as the address, with a read strobe. The data memory port presents S as the address and B as the write data, with separate read and write strobes. Instruction fields sit at fixed positions: opcode in bits 31:26, source register rs in 25:21, second register rt in 20:16, destination register rd in 15:11, function code in 5:0 and the immediate in 15:0. The PC moves only in the last step of an instruction. The branch target is formed from the PC of the branch itself, not from an incremented copy.

Top module: `mc_datapath`

## Requirements
- R1: While rst_n is low, the PC, IR, A, B, S, M and all 32 registers clear to zero. Directly after reset, imem_addr, dmem_addr, dmem_wdata and opcode read 0 and a_eq_b reads 1.
- R2: imem_addr always shows the PC and imem_rd equals ir_en. When ir_en is high, IR loads imem_rdata at the clock edge, and opcode shows IR bits 31:26.
- R3: a_en loads A from the register selected by IR[25:21]. b_en loads B from the register selected by IR[20:16]. A register written at the same edge is read with its old value.
- R4: s_en loads S with the ALU result. The second operand is the extended immediate when alu_imm is 1 and B otherwise. The immediate IR[15:0] is sign-extended when ext_sign is 1 and zero-extended otherwise. alu_op 1 gives A OR operand. alu_op 2 gives A minus operand when IR[5:0] is 6'h22 or 6'h23 and A plus operand for any other function code. alu_op 0 and 3 give A plus operand.
- R5: dmem_addr always shows S and dmem_rd equals m_en. When m_en is high, M loads dmem_rdata.
- R6: dmem_wr equals mem_wr and dmem_wdata always shows B.
- R7: When reg_wr is high, the register file writes M if wb_mem is 1, else S. The target is IR[15:11] when reg_dst is 1 and IR[20:16] otherwise. Register 0 always reads zero and ignores writes.
- R8: a_eq_b is 1 exactly when A minus B is zero.
- R9: When pc_en is high, the PC becomes PC + (sign-extended IR[15:0] shifted left by 2) if pc_br and a_eq_b are both 1, and PC + 4 otherwise.
- R10: IR, A, B, S, M and the PC keep their values in any cycle in which their own enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_en | input | 1 | Load IR from instruction memory |
| a_en | input | 1 | Load A from register rs |
| b_en | input | 1 | Load B from register rt |
| s_en | input | 1 | Load S from the ALU |
| m_en | input | 1 | Load M from data memory; data read strobe |
| pc_en | input | 1 | Update the PC |
| pc_br | input | 1 | Branch step: take the offset if A equals B |
| alu_imm | input | 1 | ALU second operand is the immediate |
| ext_sign | input | 1 | Sign-extend (1) or zero-extend (0) the immediate |
| alu_op | input | 2 | 0/3 add, 1 OR, 2 by function code |
| reg_wr | input | 1 | Register file write enable |
| reg_dst | input | 1 | Write target rd (1) or rt (0) |
| wb_mem | input | 1 | Write-back source M (1) or S (0) |
| mem_wr | input | 1 | Data memory write strobe |
| imem_addr | output | 32 | Instruction address (PC) |
| imem_rd | output | 1 | Instruction read strobe |
| imem_rdata | input | 32 | Instruction word |
| dmem_addr | output | 32 | Data address (S) |
| dmem_wdata | output | 32 | Store data (B) |
| dmem_rd | output | 1 | Data read strobe |
| dmem_wr | output | 1 | Data write strobe |
| dmem_rdata | input | 32 | Load data |
| opcode | output | 6 | IR bits 31:26 for the sequencer |
| a_eq_b | output | 1 | A equals B |

## Verification
A write-back into the register file and an operand fetch of the same register can fall in the same clock. Because the file has no bypass, the operand register must capture the value from before the write. The bench provokes this with an instruction whose rt is written by reg_wr in the same cycle that b_en reads it. It checks that store data shows the old value, then re-reads the register to see the new one. The random phase enables any mix of steps at once, so PC update, fetch and write-back also coincide freely, and every output is judged against the behavioural model on every clock.

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_en,
  input  logic        a_en,
  input  logic        b_en,
  input  logic        s_en,
  input  logic        m_en,
  input  logic        pc_en,
  input  logic        pc_br,
  input  logic        alu_imm,
  input  logic        ext_sign,
  input  logic [1:0]  alu_op,
  input  logic        reg_wr,
  input  logic        reg_dst,
  input  logic        wb_mem,
  input  logic        mem_wr,
  output logic [31:0] imem_addr,
  output logic        imem_rd,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_rd,
  output logic        dmem_wr,
  input  logic [31:0] dmem_rdata,
  output logic [5:0]  opcode,
  output logic        a_eq_b
);
  logic [31:0] pc, ir, a, b, s, m;
  logic [31:0] rf [32];
  logic [31:0] ext, opnd, alu_res, br_off, pc_next, wdata;
  logic [4:0]  rs, rt, rd, wa;
  logic        do_sub;

  assign rs = ir[25:21];
  assign rt = ir[20:16];
  assign rd = ir[15:11];
  assign wa = reg_dst ? rd : rt;
  assign wdata = wb_mem ? m : s;

  assign ext  = ext_sign ? {{16{ir[15]}}, ir[15:0]} : {16'h0, ir[15:0]};
  assign opnd = alu_imm ? ext : b;
  assign do_sub = (alu_op == 2'd2) && (ir[5:1] == 5'b10001);

  always_comb begin
    if (alu_op == 2'd1)  alu_res = a | opnd;
    else if (do_sub)     alu_res = a - opnd;
    else                 alu_res = a + opnd;
  end

  assign a_eq_b  = (a - b) == 32'd0;
  assign br_off  = {{14{ir[15]}}, ir[15:0], 2'b00};
  assign pc_next = (pc_br && a_eq_b) ? pc + br_off : pc + 32'd4;

  assign imem_addr  = pc;
  assign imem_rd    = ir_en;
  assign dmem_addr  = s;
  assign dmem_wdata = b;
  assign dmem_rd    = m_en;
  assign dmem_wr    = mem_wr;
  assign opcode     = ir[31:26];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; ir <= '0; a <= '0; b <= '0; s <= '0; m <= '0;
    end else begin
      if (pc_en) pc <= pc_next;
      if (ir_en) ir <= imem_rdata;
      if (a_en)  a  <= rf[rs];
      if (b_en)  b  <= rf[rt];
      if (s_en)  s  <= alu_res;
      if (m_en)  m  <= dmem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (reg_wr && wa != 5'd0) begin
      rf[wa] <= wdata;
    end
  end

  p_ir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_en |=> opcode == $past(imem_rdata[31:26]));
  p_m_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_en |=> m == $past(dmem_rdata));
  p_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wa != 5'd0) |=> rf[$past(wa)] == $past(wdata));
  p_r0_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf[0] == 32'd0);
  p_pc_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_en && !(pc_br && a_eq_b)) |=> imem_addr == $past(imem_addr) + 32'd4);
  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_en |=> $stable(imem_addr));
  p_s_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !s_en |=> $stable(dmem_addr));
endmodule

// File: tb/mc_datapath_bench.sv
`timescale 1ns/1ps
module mc_datapath_bench;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  localparam logic [14:0] C_IR = 15'h0001, C_A = 15'h0002, C_B = 15'h0004,
    C_S = 15'h0008, C_M = 15'h0010, C_PC = 15'h0020, C_BR = 15'h0040,
    C_IMM = 15'h0080, C_SX = 15'h0100, C_RW = 15'h0200, C_RD = 15'h0400,
    C_WM = 15'h0800, C_MW = 15'h1000, C_OR = 15'h2000, C_FN = 15'h4000;

  logic [14:0] ctl = '0;
  logic [31:0] imem_rdata = '0, dmem_rdata = '0;
  logic [31:0] imem_addr, dmem_addr, dmem_wdata;
  logic imem_rd, dmem_rd, dmem_wr, a_eq_b;
  logic [5:0] opcode;

  mc_datapath u_mc_datapath (
    .clk(clk), .rst_n(rst_n),
    .ir_en(ctl[0]), .a_en(ctl[1]), .b_en(ctl[2]), .s_en(ctl[3]), .m_en(ctl[4]),
    .pc_en(ctl[5]), .pc_br(ctl[6]), .alu_imm(ctl[7]), .ext_sign(ctl[8]),
    .alu_op(ctl[14:13]), .reg_wr(ctl[9]), .reg_dst(ctl[10]), .wb_mem(ctl[11]),
    .mem_wr(ctl[12]),
    .imem_addr(imem_addr), .imem_rd(imem_rd), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rd(dmem_rd),
    .dmem_wr(dmem_wr), .dmem_rdata(dmem_rdata), .opcode(opcode), .a_eq_b(a_eq_b));

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference model
  logic [31:0] mpc, mir, ma, mb, ms, mm;
  logic [31:0] mrf [32];
  always @(posedge clk or negedge rst_n) begin
    logic [31:0] sec, ext, res, npc, wd;
    logic [4:0] tgt;
    if (!rst_n) begin
      mpc = 0; mir = 0; ma = 0; mb = 0; ms = 0; mm = 0;
      for (int i = 0; i < 32; i++) mrf[i] = 0;
    end else begin
      ext = ctl[8] ? 32'($signed(mir[15:0])) : {16'h0, mir[15:0]};
      sec = ctl[7] ? ext : mb;
      case (ctl[14:13])
        2'd1: res = ma | sec;
        2'd2: res = (mir[5:0] == 6'h22 || mir[5:0] == 6'h23) ? ma - sec : ma + sec;
        default: res = ma + sec;
      endcase
      npc = (ctl[6] && ma == mb) ? mpc + (32'($signed(mir[15:0])) * 4) : mpc + 4;
      tgt = ctl[10] ? mir[15:11] : mir[20:16];
      wd = ctl[11] ? mm : ms;
      if (ctl[1]) ma = mrf[mir[25:21]];
      if (ctl[2]) mb = mrf[mir[20:16]];
      if (ctl[3]) ms = res;
      if (ctl[4]) mm = dmem_rdata;
      if (ctl[5]) mpc = npc;
      if (ctl[0]) mir = imem_rdata;
      if (ctl[9] && tgt != 0) mrf[tgt] = wd;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    logic [105:0] act, exp;
    act = {imem_addr, dmem_addr, dmem_wdata, opcode, a_eq_b, imem_rd, dmem_rd, dmem_wr};
    exp = {mpc, ms, mb, mir[31:26], ma == mb, ctl[0], ctl[4], ctl[12]};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL model actual=%h expected=%h", act, exp);
    end
  endtask

  task automatic step(logic [14:0] c, logic [31:0] iw = 0, logic [31:0] dw = 0);
    ctl = c; imem_rdata = iw; dmem_rdata = dw;
    @(negedge clk);
    ctl = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pc", imem_addr, 0); chk("R1 s", dmem_addr, 0);
    chk("R1 b", dmem_wdata, 0); chk("R1 op", {26'h0, opcode}, 0);
    chk("R1 eq", {31'h0, a_eq_b}, 1);
    rst_n = 1;
    @(negedge clk);
    // ori r1, r0, 0x1234
    ctl = C_IR; imem_rdata = 32'h34011234; #1;
    chk("R2 imem_rd", {31'h0, imem_rd}, 1);
    @(negedge clk); ctl = '0;
    chk("R2 opcode", {26'h0, opcode}, 6'h0D);
    step(C_A | C_B);
    step(C_S | C_IMM | C_OR);
    chk("R4 or zero-ext", dmem_addr, 32'h1234);
    step(C_RW | C_PC);
    chk("R9 pc+4", imem_addr, 4);
    // sw r1, -4(r0)
    step(C_IR, 32'hAC01FFFC);
    step(C_A | C_B);
    chk("R3 rt read", dmem_wdata, 32'h1234);
    step(C_S | C_IMM | C_SX);
    chk("R4 sign-ext add", dmem_addr, 32'hFFFFFFFC);
    ctl = C_MW; #1;
    chk("R6 write strobe", {31'h0, dmem_wr}, 1);
    @(negedge clk); ctl = '0;
    // collision: write r1 while reading it
    step(C_IR, 32'h00211021);
    step(C_B | C_RW);
    chk("R3 old value on same-edge write", dmem_wdata, 32'h1234);
    step(C_B);
    chk("R7 write to rt visible", dmem_wdata, 32'hFFFFFFFC);
    // write to r0 ignored
    step(C_IR, 32'h00000000);
    step(C_RW | C_RD);
    step(C_B);
    chk("R7 r0 stays zero", dmem_wdata, 0);
    // beq r0, r0, +3
    step(C_IR, 32'h10000003);
    step(C_A | C_B);
    chk("R8 equal", {31'h0, a_eq_b}, 1);
    step(C_PC | C_BR);
    chk("R9 taken branch", imem_addr, 16);
    // beq r1, r0 not taken
    step(C_IR, 32'h10200005);
    step(C_A | C_B);
    chk("R8 unequal", {31'h0, a_eq_b}, 0);
    step(C_PC | C_BR);
    chk("R9 not taken", imem_addr, 20);
    // lw r3
    step(C_IR, 32'h8C030000);
    ctl = C_M; dmem_rdata = 32'hCAFEF00D; #1;
    chk("R5 read strobe", {31'h0, dmem_rd}, 1);
    @(negedge clk); ctl = '0;
    step(C_RW | C_WM);
    step(C_B);
    chk("R5 R7 load write-back", dmem_wdata, 32'hCAFEF00D);
    // hold with enables low
    step(0, 32'hFFFFFFFF, 32'h12345678);
    step(0, 32'h0BADBEEF, 32'h0);
    chk("R10 pc hold", imem_addr, 20); chk("R10 s hold", dmem_addr, 32'hFFFFFFFC);
    chk("R10 b hold", dmem_wdata, 32'hCAFEF00D); chk("R10 ir hold", {26'h0, opcode}, 6'h23);
    // sub r3 - r1 via function code
    step(C_IR, 32'h00610023);
    step(C_A | C_B);
    step(C_S | C_FN);
    chk("R4 subtract", dmem_addr, 32'hCAFEF011);
    // random phase against model
    for (int k = 0; k < 4000; k++) begin
      ctl = 15'($urandom);
      imem_rdata = $urandom; dmem_rdata = $urandom;
      #1 cmp_model();
      @(negedge clk);
      cmp_model();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule